// File: doc/BRIEF.md
# E1 Timeslot-0 Si/Sa Bit Inserter

This block assembles the timeslot-0 byte of each outgoing E1 frame. On frames that carry the frame alignment word, the byte comes from a host-written alignment byte. On the other frames, it comes from a host-written non-alignment byte. The block forces no bit in either byte. Each byte goes out exactly as the host programmed it, including the alignment word and the fixed-one position.

A per-position select byte can replace the international (Si) bits, the remote alarm bit and the five spare (Sa4 to Sa8) bits with serial data. That data comes from eight per-multiframe transmit bytes. At every multiframe start, the block copies these bytes into internal shift registers and raises a sticky status flag. The flag tells the host that it can load the values for the next multiframe. If the host does not write new values, the same data is copied again and sent again. Each shift register sends its most significant bit first and moves one bit per frame that uses it. The alignment-frame Si register moves on alignment frames, and the other seven move on non-alignment frames.

Top module: `e1_ts0_inserter`

## Requirements
- R1: After reset, `ts0_byte` is 0x00 and `mf_flag` is 0.
- R2: On the clock edge where `frame_stb` is high with `align_frm` high, `ts0_byte` loads the alignment byte (address 0). Bits 6..0 are always the stored value. Bit 7 is the stored value when select bit 7 is 0.
- R3: On the edge where `frame_stb` is high with `align_frm` low, `ts0_byte` loads the non-alignment byte (address 1) unchanged at every position whose select bit is 0. Bit 6 is never forced to one and is never replaced.
- R4: The select byte is at address 2. Select bit 7 replaces alignment-frame bit 7 with a bit from the Si-alignment register. Select bit 6 replaces non-alignment bit 7 with a bit from the Si-non-alignment register. Select bit 5 replaces non-alignment bit 5 with a bit from the alarm register. Select bits 4..0 replace non-alignment bits 4..0 with bits from the Sa4..Sa8 registers.
- R5: The eight multiframe registers are at addresses 4..11, in this order: Si-alignment, Si-non-alignment, alarm, Sa4, Sa5, Sa6, Sa7, Sa8. The n-th alignment frame of a multiframe (n = 0..7) uses bit 7-n of the Si-alignment register. The n-th non-alignment frame uses bit 7-n of each of the other seven registers.
- R6: A frame strobe with `mf_stb` high starts a multiframe and copies all eight registers. Host writes after that edge do not change the bits sent in that multiframe. They take effect at the next multiframe start.
- R7: When the host writes nothing between two multiframe starts, the second multiframe sends the same bits as the first.
- R8: `mf_flag` goes to 1 on the edge of each multiframe start and stays at 1. Writing the status address (3) with data bit 0 set clears the flag. Writing it with bit 0 clear has no effect. A multiframe start in the same cycle as a clear leaves the flag set.
- R9: `ts0_byte` does not change on any cycle without `frame_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe at each frame |
| align_frm | input | 1 | Current frame carries the alignment word (valid with `frame_stb`) |
| mf_stb | input | 1 | Current frame is the first of a multiframe (valid with `frame_stb`) |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data |
| ts0_byte | output | 8 | Timeslot-0 byte of the current frame |
| mf_flag | output | 1 | Sticky multiframe-start flag |

## Verification
`ts0_byte` and `mf_flag` each sit behind exactly one register. The result of a frame strobe or of a host write is therefore due on the first rising edge after that input.

The driver applies every input on a falling edge. At the same moment it pushes the byte that the requirements predict. The monitor remembers whether a strobe was present at the rising edge, and it compares on the next falling edge, one cycle after the strobe. On each idle cycle between strobes, the monitor also checks that the byte is unchanged. The flag is checked on the falling edge right after the frame or write that affects it.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
   localparam int BYTE_W   = 8;
   localparam int NUM_MF   = 8;
   // host address map
   localparam int A_ALIGN  = 0;
   localparam int A_NALIGN = 1;
   localparam int A_SEL    = 2;
   localparam int A_STAT   = 3;
   localparam int A_MF0    = 4;
   // multiframe register order
   localparam int MF_SI_AL = 0;
   localparam int MF_SI_NA = 1;
   localparam int MF_ALARM = 2;
   localparam int MF_SA4   = 3;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/e1_ts0_hostregs.sv
module e1_ts0_hostregs
   import e1_ts0_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int STAT_BIT = 0,
   parameter bit SET_WINS = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [BYTE_W-1:0]            wr_data,
   input  logic                         mf_evt,
   output logic [BYTE_W-1:0]            align_q,
   output logic [BYTE_W-1:0]            nalign_q,
   output logic [BYTE_W-1:0]            sel_q,
   output logic [NUM_MF-1:0][BYTE_W-1:0] mf_q,
   output logic                         flag_q
);
   localparam int TOP_ADDR = A_MF0 + NUM_MF - 1;

   generate
      if ((1 << ADDR_W) <= TOP_ADDR) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
      if (STAT_BIT >= BYTE_W) begin : g_bad_stat
         $error("STAT_BIT outside the data byte");
      end
   endgenerate

   logic clr_req;
   assign clr_req = wr_en && (wr_addr == ADDR_W'(A_STAT)) && wr_data[STAT_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         align_q  <= '0;
         nalign_q <= '0;
         sel_q    <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(A_ALIGN))  align_q  <= wr_data;
         if (wr_addr == ADDR_W'(A_NALIGN)) nalign_q <= wr_data;
         if (wr_addr == ADDR_W'(A_SEL))    sel_q    <= wr_data;
      end
   end

   genvar k;
   generate
      for (k = 0; k < NUM_MF; k++) begin : g_mf
         always_ff @(posedge clk) begin
            if (!rst_n)
               mf_q[k] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(A_MF0 + k))
               mf_q[k] <= wr_data;
         end
      end

      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk) begin
            if (!rst_n)       flag_q <= 1'b0;
            else if (mf_evt)  flag_q <= 1'b1;
            else if (clr_req) flag_q <= 1'b0;
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk) begin
            if (!rst_n)       flag_q <= 1'b0;
            else if (clr_req) flag_q <= 1'b0;
            else if (mf_evt)  flag_q <= 1'b1;
         end
      end
   endgenerate

   // R8: a multiframe start always leaves the flag set
   p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mf_evt && (SET_WINS || !clr_req) |=> flag_q);
   // R8: the flag stays set unless a clear is requested
   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clr_req |=> flag_q);
   // R8: a clear without a multiframe start drops the flag
   p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req && !mf_evt |=> !flag_q);
endmodule

// File: rtl/e1_ts0_mfshift.sv
module e1_ts0_mfshift
   import e1_ts0_pkg::*;
(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          frame_stb,
   input  logic                          align_frm,
   input  logic                          mf_evt,
   input  logic [NUM_MF-1:0][BYTE_W-1:0] load_val,
   output logic [NUM_MF-1:0]             cur_bit
);
   genvar k;
   generate
      for (k = 0; k < NUM_MF; k++) begin : g_sh
         logic [BYTE_W-1:0] sh_q;
         logic [BYTE_W-1:0] src;
         logic              uses;

         if (k == MF_SI_AL) begin : g_al
            assign uses = align_frm;
         end else begin : g_na
            assign uses = !align_frm;
         end

         assign src        = mf_evt ? load_val[k] : sh_q;
         assign cur_bit[k] = src[BYTE_W-1];

         always_ff @(posedge clk) begin
            if (!rst_n)
               sh_q <= '0;
            else if (frame_stb && uses)
               sh_q <= {src[BYTE_W-2:0], 1'b0};
            else if (mf_evt)
               sh_q <= src;
         end
      end
   endgenerate
endmodule

// File: rtl/e1_ts0_assemble.sv
module e1_ts0_assemble
   import e1_ts0_pkg::*;
(
   input  logic              align_frm,
   input  logic [BYTE_W-1:0] align_q,
   input  logic [BYTE_W-1:0] nalign_q,
   input  logic [BYTE_W-1:0] sel_q,
   input  logic [NUM_MF-1:0] cur_bit,
   output logic [BYTE_W-1:0] byte_nxt
);
   logic [BYTE_W-1:0] al_byte;
   logic [BYTE_W-1:0] na_byte;

   assign al_byte = {sel_q[7] ? cur_bit[MF_SI_AL] : align_q[7], align_q[6:0]};

   assign na_byte[7] = sel_q[6] ? cur_bit[MF_SI_NA] : nalign_q[7];
   assign na_byte[6] = nalign_q[6];
   assign na_byte[5] = sel_q[5] ? cur_bit[MF_ALARM] : nalign_q[5];

   genvar p;
   generate
      for (p = 0; p < 5; p++) begin : g_sa
         // bit 4 carries Sa4 ... bit 0 carries Sa8
         assign na_byte[p] = sel_q[p] ? cur_bit[MF_SA4 + 4 - p] : nalign_q[p];
      end
   endgenerate

   assign byte_nxt = align_frm ? al_byte : na_byte;
endmodule

// File: rtl/e1_ts0_inserter.sv
module e1_ts0_inserter
   import e1_ts0_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int STAT_BIT = 0,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              align_frm,
   input  logic              mf_stb,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic [7:0]        ts0_byte,
   output logic              mf_flag
);
   generate
      if (BYTE_W != 8 || NUM_MF != 8) begin : g_bad_shape
         $error("E1 timeslot-0 layout needs 8-bit bytes and 8 multiframe registers");
      end
   endgenerate

   logic                          mf_evt;
   logic [BYTE_W-1:0]             align_q, nalign_q, sel_q, byte_nxt;
   logic [NUM_MF-1:0][BYTE_W-1:0] mf_q;
   logic [NUM_MF-1:0]             cur_bit;

   assign mf_evt = frame_stb && mf_stb;

   e1_ts0_hostregs #(
      .ADDR_W  (ADDR_W),
      .STAT_BIT(STAT_BIT),
      .SET_WINS(SET_WINS)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .mf_evt  (mf_evt),
      .align_q (align_q),
      .nalign_q(nalign_q),
      .sel_q   (sel_q),
      .mf_q    (mf_q),
      .flag_q  (mf_flag)
   );

   e1_ts0_mfshift i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_stb(frame_stb),
      .align_frm(align_frm),
      .mf_evt   (mf_evt),
      .load_val (mf_q),
      .cur_bit  (cur_bit)
   );

   e1_ts0_assemble i_asm (
      .align_frm(align_frm),
      .align_q  (align_q),
      .nalign_q (nalign_q),
      .sel_q    (sel_q),
      .cur_bit  (cur_bit),
      .byte_nxt (byte_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         ts0_byte <= '0;
      else if (frame_stb) ts0_byte <= byte_nxt;
   end

   // R9: no strobe, no change
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(ts0_byte));
   // R2: the alignment word goes out as stored
   p_align_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb && align_frm |=> ts0_byte[6:0] == $past(align_q[6:0]));
   // R3: the fixed position is sent as stored, never forced
   p_fixed_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb && !align_frm |=> ts0_byte[6] == $past(nalign_q[6]));
   // R4: with nothing selected, the non-alignment byte passes unchanged
   p_no_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb && !align_frm && sel_q[6:0] == 7'd0 |=> ts0_byte == $past(nalign_q));
endmodule

// File: tb/test_e1_ts0_inserter.sv
module test_e1_ts0_inserter;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_stb = 1'b0, align_frm = 1'b0, mf_stb = 1'b0;
   logic wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] ts0_byte;
   logic mf_flag;

   int checks = 0;
   int errors = 0;

   // model state
   logic [7:0] m_align = '0, m_nalign = '0, m_sel = '0;
   logic [7:0] m_mf [8];
   logic [7:0] snap [8];
   int ia = 0, in_ = 0;
   bit m_flag = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] last_exp = 8'h00;
   string      last_tag = "R1";
   bit         stb_seen = 1'b0;

   e1_ts0_inserter #(.ADDR_W(ADDR_W)) i_e1_ts0_inserter (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .align_frm(align_frm),
      .mf_stb(mf_stb), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ts0_byte(ts0_byte), .mf_flag(mf_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: compare one cycle after every strobe, hold check otherwise
   always @(posedge clk) stb_seen <= frame_stb;

   always @(negedge clk) begin
      if (rst_n) begin
         if (stb_seen) begin
            if (exp_q.size() == 0) begin
               check("R9 unexpected strobe", 32'd1, 32'd0);
            end else begin
               last_exp = exp_q.pop_front();
               last_tag = tag_q.pop_front();
               check(last_tag, {24'd0, ts0_byte}, {24'd0, last_exp});
            end
         end else begin
            check((last_tag == "R1") ? "R1" : "R9", {24'd0, ts0_byte}, {24'd0, last_exp});
         end
      end
   end

   task automatic host_wr(input int addr, input logic [7:0] data);
      wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
      case (addr)
         0: m_align = data;
         1: m_nalign = data;
         2: m_sel = data;
         3: if (data[0]) m_flag = 1'b0;
         default: if (addr >= 4 && addr < 12) m_mf[addr-4] = data;
      endcase
   endtask

   task automatic do_frame(input int idx, input bit clr, input string tag);
      bit mf = (idx == 0);
      bit al = (idx % 2 == 0);
      logic [7:0] e;
      if (mf) begin
         for (int k = 0; k < 8; k++) snap[k] = m_mf[k];
         ia = 0; in_ = 0;
      end
      if (al) begin
         e = m_align;
         if (m_sel[7]) e[7] = snap[0][7-(ia & 7)];
         ia++;
      end else begin
         e = m_nalign;
         if (m_sel[6]) e[7] = snap[1][7-(in_ & 7)];
         if (m_sel[5]) e[5] = snap[2][7-(in_ & 7)];
         for (int p = 0; p < 5; p++)
            if (m_sel[p]) e[p] = snap[7-p][7-(in_ & 7)];
         in_++;
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
      frame_stb = 1'b1; align_frm = al; mf_stb = mf;
      if (clr) begin wr_en = 1'b1; wr_addr = ADDR_W'(3); wr_data = 8'h01; end
      @(negedge clk);
      frame_stb = 1'b0; mf_stb = 1'b0; wr_en = 1'b0;
      if (mf) m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
      if (mf || clr) check("R8 flag after frame", {31'd0, mf_flag}, {31'd0, m_flag});
      repeat (2) @(negedge clk);
   endtask

   task automatic run_frames(input int lo, input int hi, input int clr_at, input string tag);
      for (int i = lo; i <= hi; i++) do_frame(i, i == clr_at, tag);
   endtask

   initial begin
      bit done = 1'b0;
      fork
         begin
            repeat (100000) @(posedge clk);
            if (!done) begin
               errors++;
               checks++;
               $display("FAIL watchdog: actual timeout expected completion");
               $display("Simulation finished: %0d checks, %0d errors", checks, errors);
               $finish;
            end
         end
      join_none

      for (int k = 0; k < 8; k++) begin m_mf[k] = '0; snap[k] = '0; end
      repeat (4) @(negedge clk);
      check("R1 byte", {24'd0, ts0_byte}, 32'h0);
      check("R1 flag", {31'd0, mf_flag}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2, R3: static bytes pass unchanged
      host_wr(0, 8'h9B);
      host_wr(1, 8'h5F);
      host_wr(2, 8'h00);
      run_frames(0, 15, -1, "R2/R3 static");
      check("R8 flag set", {31'd0, mf_flag}, 32'h1);
      host_wr(3, 8'h00);
      check("R8 no clear", {31'd0, mf_flag}, 32'h1);
      host_wr(3, 8'h01);
      check("R8 cleared", {31'd0, mf_flag}, 32'h0);

      // R2, R3: nothing forced
      host_wr(0, 8'h00);
      host_wr(1, 8'h00);
      run_frames(0, 15, -1, "R2/R3 unforced");

      // R4, R5: all positions from multiframe registers
      host_wr(0, 8'h1B);
      host_wr(1, 8'h40);
      host_wr(2, 8'hFF);
      host_wr(4, 8'hA5); host_wr(5, 8'h3C); host_wr(6, 8'hF0); host_wr(7, 8'h0F);
      host_wr(8, 8'h81); host_wr(9, 8'h66); host_wr(10, 8'h99); host_wr(11, 8'hC3);
      run_frames(0, 15, -1, "R4/R5 serial");

      // R6: writes mid-multiframe wait for the next start
      run_frames(0, 5, -1, "R6 before write");
      host_wr(4, 8'h5A); host_wr(5, 8'hC3); host_wr(6, 8'h0F); host_wr(7, 8'hF0);
      host_wr(8, 8'h7E); host_wr(9, 8'h99); host_wr(10, 8'h66); host_wr(11, 8'h3C);
      run_frames(6, 15, -1, "R6 old snapshot");
      run_frames(0, 15, -1, "R6 new snapshot");

      // R7: no reload resends the same data
      run_frames(0, 15, -1, "R7 resend");

      // R4: mixed selection
      host_wr(2, 8'hA5);
      host_wr(1, 8'h5A);
      run_frames(0, 15, -1, "R4 mixed select");

      // R8: clear together with a start leaves the flag set, a later clear drops it
      run_frames(0, 1, 0, "R8 clear at start");
      run_frames(0, 3, 1, "R8 clear mid");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) check("R9 pending items", exp_q.size(), 32'd0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule